// File: doc/BRIEF.md
# Bit Centrifuge Execution Unit

This unit separates the bits of a 64-bit source word into two groups chosen by a 64-bit mask word. Source bits whose mask bit is clear are gathered at the most significant end of the result. Source bits whose mask bit is set are gathered at the least significant end. Inside each group the bits keep the order they had in the source. A processor pipeline issues an operation with a single-cycle `start_i` pulse. It then waits for the one-cycle `done_o` pulse, which marks `result_o` as valid.

The unit does not visit the mask one bit at a time. Each cycle it consumes one maximal run of equal mask bits, starting from bit 0. The run length comes from a combinational trailing-zero counter, and the mask is inverted after every step so that the next run is also found by counting trailing zeros. Bits taken during a clear-mask run are rotated into a high-side accumulator. Bits taken during a set-mask run are rotated into a low-side accumulator. One closing cycle shifts the low-side accumulator into place, using the population count of the final mask, and merges the two halves. A mask that is all zeros or all ones skips the iteration and returns the source unchanged.

Top module: `bit_centrifuge_unit`

## Requirements
- R1: A synchronous active-low reset clears `busy_o`, `done_o` and `result_o` to 0, including a reset asserted while an operation is running.
- R2: When `start_i` is accepted with `mask_i` equal to all zeros or all ones, `done_o` pulses on the next clock edge with `result_o` equal to `src_i`, and `busy_o` never rises.
- R3: Every source bit at a position where the mask bit is 0 appears in the top part of `result_o`. The lowest such bit lands just above the set-mask group, and the zero-selected bits keep their source order.
- R4: Every source bit at a position where the mask bit is 1 appears in the bottom part of `result_o`. The lowest such bit lands at bit 0, and the one-selected bits keep their source order.
- R5: For any other mask, count S as the number of maximal runs of equal mask bits, plus one more when mask bit 0 is 1. `done_o` then pulses exactly S+2 clock edges after the edge that accepted `start_i`, counting that edge as the first. `busy_o` is high from the accepting edge until `done_o` rises. The worst case is 67 edges, for an alternating mask with bit 0 set.
- R6: `done_o` lasts a single cycle, and `busy_o` is low while it is high. `result_o` holds its value from one completion until the next completion or reset.
- R7: A `start_i` pulse that arrives while `busy_o` is high has no effect. The running operation returns its own result with its own latency, and no additional `done_o` pulse follows.
- R8: When the run that reaches the most significant bit is cut short by the bit budget, the trailing-zero count is clamped to the remaining bits. A single set bit at bit 63 therefore yields 1 for a source of 0x8000000000000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request; operands sampled on the same edge |
| src_i | input | 64 | Source word |
| mask_i | input | 64 | Selection mask: 0 sends a bit high, 1 sends it low |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Centrifuged result, valid with `done_o` and held afterwards |

## Verification
For a mask that is all zeros or all ones, the result is due one edge after the accepting edge. For any other mask it is due S+2 edges after, where the bench computes S from the mask itself by counting the runs, plus one when bit 0 is set. The bench drives `start_i` at a falling edge and samples every output at later falling edges, counting edges until `done_o` appears. That count must equal the predicted latency exactly. The cycle after each completion is also sampled, to confirm that the pulse has ended and that the result is still held.

// File: rtl/bcu_pkg.sv
// Package bcu_pkg: shared width and controller state encoding for the
// bit centrifuge unit. Assumes the datapath width is a power of two.
package bcu_pkg;
    parameter int unsigned DATA_W = 64;

    // Controller phases: waiting, consuming runs, closing merge
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } bcu_state_e;
endpackage

// File: rtl/bcu_tzcnt.sv
// bcu_tzcnt: combinational priority encoder that returns the number of
// trailing zero bits of vec_i. An all-zero vector gives W. Assumes CW bits
// are enough to hold W.
module bcu_tzcnt #(
    parameter int unsigned W  = bcu_pkg::DATA_W,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    // Scan from the top down so that the lowest set bit wins
    always_comb begin
        cnt_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                cnt_o = CW'(i);
            end
        end
    end
endmodule

// File: rtl/bcu_popcnt.sv
// bcu_popcnt: combinational population count of vec_i. Assumes CW bits
// can hold W.
module bcu_popcnt #(
    parameter int unsigned W  = bcu_pkg::DATA_W,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    // Add up every set bit of the vector
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/bcu_run_step.sv
// bcu_run_step: one iteration of the run walk. It takes the low n source
// bits, where n is the current run length clamped to the remaining budget,
// ORs them into the accumulator of the current run type and rotates that
// accumulator right by n. It then shifts source and mask right by n,
// inverts the mask and toggles the run type. Purely combinational.
// Assumes rem_i <= W.
module bcu_run_step #(
    parameter int unsigned W  = bcu_pkg::DATA_W,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  src_i,
    input  logic [W-1:0]  mask_i,
    input  logic [W-1:0]  lo_acc_i,
    input  logic [W-1:0]  hi_acc_i,
    input  logic [CW-1:0] rem_i,
    input  logic          run_one_i,
    output logic [W-1:0]  src_o,
    output logic [W-1:0]  mask_o,
    output logic [W-1:0]  lo_acc_o,
    output logic [W-1:0]  hi_acc_o,
    output logic [CW-1:0] rem_o,
    output logic          run_one_o
);
    logic [CW-1:0] tz_cnt;
    logic [CW-1:0] take_n;
    logic [W-1:0]  take_msk;
    logic [W-1:0]  picked;

    // Rotate right by 0..W; a shift by W yields zero, so both ends behave
    function automatic logic [W-1:0] rot_r(input logic [W-1:0] x, input logic [CW-1:0] n);
        return (x >> n) | (x << (CW'(W) - n));
    endfunction

    bcu_tzcnt #(.W(W), .CW(CW)) u_tz (
        .vec_i (mask_i),
        .cnt_o (tz_cnt)
    );

    // Clamp the run length to the bits still unprocessed
    always_comb begin
        take_n = (tz_cnt > rem_i) ? rem_i : tz_cnt;
    end

    // Select the low take_n source bits
    always_comb begin
        if (int'(take_n) >= int'(W)) begin
            take_msk = '1;
        end else begin
            take_msk = (W'(1) << take_n) - W'(1);
        end
        picked = src_i & take_msk;
    end

    // Insert the picked bits into the accumulator of the current run type
    always_comb begin
        lo_acc_o = lo_acc_i;
        hi_acc_o = hi_acc_i;
        if (run_one_i) begin
            hi_acc_o = rot_r(hi_acc_i | picked, take_n);
        end else begin
            lo_acc_o = rot_r(lo_acc_i | picked, take_n);
        end
    end

    // Drop the consumed bits and prepare for the opposite run type
    always_comb begin
        src_o     = src_i >> take_n;
        mask_o    = ~(mask_i >> take_n);
        rem_o     = rem_i - take_n;
        run_one_o = ~run_one_i;
    end
endmodule

// File: rtl/bcu_align.sv
// bcu_align: closing merge. Shifts the set-mask accumulator down by the
// population count of the final mask (or W minus it, depending on the last
// run type) and ORs it with the clear-mask accumulator. Combinational.
module bcu_align #(
    parameter int unsigned W  = bcu_pkg::DATA_W,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0] lo_acc_i,
    input  logic [W-1:0] hi_acc_i,
    input  logic [W-1:0] mask_i,
    input  logic         run_one_i,
    output logic [W-1:0] merged_o
);
    logic [CW-1:0] pop;
    logic [CW-1:0] shamt;

    bcu_popcnt #(.W(W), .CW(CW)) u_pop (
        .vec_i (mask_i),
        .cnt_o (pop)
    );

    // Pick the alignment distance and merge the two groups
    always_comb begin
        shamt    = run_one_i ? pop : (CW'(W) - pop);
        merged_o = lo_acc_i | (hi_acc_i >> shamt);
    end
endmodule

// File: rtl/bit_centrifuge_unit.sv
// bit_centrifuge_unit: multi-cycle centrifuge. Clear-mask source bits go to
// the high end and set-mask bits to the low end, each group in source order.
// It consumes one mask run per cycle and finishes with one merge cycle.
// Trivial masks (all zeros / all ones) return the source after one edge.
// Assumes start_i is a single-cycle request; a request while busy is dropped.
module bit_centrifuge_unit #(
    parameter int unsigned W = bcu_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] mask_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    localparam int unsigned CW = $clog2(W + 1);

    bcu_pkg::bcu_state_e state_q;
    logic [W-1:0]  src_q, mask_q, lo_q, hi_q, result_q;
    logic [CW-1:0] rem_q;
    logic          one_q, done_q;

    logic [W-1:0]  src_nx, mask_nx, lo_nx, hi_nx, merged;
    logic [CW-1:0] rem_nx;
    logic          one_nx;
    logic          trivial;

    // Detect masks that leave the source unchanged
    always_comb begin
        trivial = (mask_i == '0) || (mask_i == '1);
    end

    bcu_run_step #(.W(W), .CW(CW)) u_step (
        .src_i     (src_q),
        .mask_i    (mask_q),
        .lo_acc_i  (lo_q),
        .hi_acc_i  (hi_q),
        .rem_i     (rem_q),
        .run_one_i (one_q),
        .src_o     (src_nx),
        .mask_o    (mask_nx),
        .lo_acc_o  (lo_nx),
        .hi_acc_o  (hi_nx),
        .rem_o     (rem_nx),
        .run_one_o (one_nx)
    );

    bcu_align #(.W(W), .CW(CW)) u_align (
        .lo_acc_i  (lo_q),
        .hi_acc_i  (hi_q),
        .mask_i    (mask_q),
        .run_one_i (one_q),
        .merged_o  (merged)
    );

    // Controller: accept, iterate over runs, merge, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= bcu_pkg::ST_IDLE;
            src_q    <= '0;
            mask_q   <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            rem_q    <= '0;
            one_q    <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                bcu_pkg::ST_IDLE: begin
                    if (start_i) begin
                        if (trivial) begin
                            result_q <= src_i;
                            done_q   <= 1'b1;
                        end else begin
                            src_q   <= src_i;
                            mask_q  <= mask_i;
                            lo_q    <= '0;
                            hi_q    <= '0;
                            rem_q   <= CW'(W);
                            one_q   <= 1'b0;
                            state_q <= bcu_pkg::ST_RUN;
                        end
                    end
                end
                bcu_pkg::ST_RUN: begin
                    src_q  <= src_nx;
                    mask_q <= mask_nx;
                    lo_q   <= lo_nx;
                    hi_q   <= hi_nx;
                    rem_q  <= rem_nx;
                    one_q  <= one_nx;
                    if (rem_nx == '0) begin
                        state_q <= bcu_pkg::ST_FIN;
                    end
                end
                bcu_pkg::ST_FIN: begin
                    result_q <= merged;
                    done_q   <= 1'b1;
                    state_q  <= bcu_pkg::ST_IDLE;
                end
                default: state_q <= bcu_pkg::ST_IDLE;
            endcase
        end
    end

    // Drive the outputs from registered state
    always_comb begin
        busy_o   = (state_q != bcu_pkg::ST_IDLE);
        done_o   = done_q;
        result_o = result_q;
    end
endmodule

// File: rtl/bcu_checker.sv
// bcu_checker: protocol and timing properties of bit_centrifuge_unit,
// observed only at its ports. Attached with the bind below.
module bcu_checker #(
    parameter int unsigned W = bcu_pkg::DATA_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] src_i,
    input logic [W-1:0] mask_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o
);
    localparam int unsigned BW = $clog2(W + 4) + 1;
    logic [BW-1:0] busy_run;

    // Count consecutive busy cycles to bound the latency
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + 1'b1;
        else busy_run <= '0;
    end

    // R2: a trivial mask returns the source on the next edge
    a_r2_bypass_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (mask_i == '0 || mask_i == '1))
        |=> (done_o && !busy_o && result_o == $past(src_i)));

    // R5: a non-trivial request makes the unit busy without completing
    a_r5_enter_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && mask_i != '0 && mask_i != '1) |=> (busy_o && !done_o));

    // R5: never busy longer than the worst case of W+2 cycles
    a_r5_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(busy_run) <= int'(W) + 2));

    // R6: completion and busy are exclusive
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: the result only changes together with a completion
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || !start_i) |=> (done_o || $stable(result_o)));

    // R7: a request while busy cannot end the operation without done
    a_r7_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind bit_centrifuge_unit bcu_checker #(.W(W)) u_bcu_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .src_i    (src_i),
    .mask_i   (mask_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/bit_centrifuge_unit_test.sv
`timescale 1ns/1ps
module bit_centrifuge_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] src_i = '0;
    logic [63:0] mask_i = '0;
    logic        busy_o, done_o;
    logic [63:0] result_o;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bit_centrifuge_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i),
        .mask_i(mask_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    // {src, mask, expected}
    localparam int NV = 8;
    localparam logic [191:0] VEC [NV] = '{
        {64'h1111111122222222, 64'hFFFFFFFF00000000, 64'h2222222211111111},
        {64'h1111111122222222, 64'h00000000FFFFFFFF, 64'h1111111122222222},
        {64'h0000000000000001, 64'h0000000000000001, 64'h0000000000000001},
        {64'h8000000000000000, 64'h8000000000000000, 64'h0000000000000001},
        {64'hDEADBEEFCAFEF00D, 64'h0000000000000000, 64'hDEADBEEFCAFEF00D},
        {64'hDEADBEEFCAFEF00D, 64'hFFFFFFFFFFFFFFFF, 64'hDEADBEEFCAFEF00D},
        {64'h00000000000000FF, 64'h5555555555555555, 64'h0000000F0000000F},
        {64'hFFFFFFFF00000000, 64'hAAAAAAAAAAAAAAAA, 64'hFFFF0000FFFF0000}
    };

    function automatic logic [63:0] ref_model(input logic [63:0] s, input logic [63:0] m);
        logic [63:0] r = '0;
        int k = 0;
        for (int i = 0; i < 64; i++) if (m[i]) begin r[k] = s[i]; k++; end
        k = 63;
        for (int i = 63; i >= 0; i--) if (!m[i]) begin r[k] = s[i]; k--; end
        return r;
    endfunction

    function automatic int exp_latency(input logic [63:0] m);
        int s;
        if (m == '0 || m == '1) return 1;
        s = 1 + (m[0] ? 1 : 0);
        for (int i = 1; i < 64; i++) if (m[i] != m[i-1]) s++;
        return s + 2;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [63:0] s, input logic [63:0] m,
                         output logic [63:0] r, output int cyc);
        @(negedge clk);
        start_i = 1'b1; src_i = s; mask_i = m;
        @(negedge clk);
        start_i = 1'b0; cyc = 1;
        while (!done_o && cyc < 200) begin @(negedge clk); cyc++; end
        r = result_o;
    endtask

    task automatic run_and_check(input logic [63:0] s, input logic [63:0] m,
                                 input logic [63:0] exp, input string tag);
        logic [63:0] r;
        int cyc;
        do_op(s, m, r, cyc);
        chk({tag, " R3 R4 result"}, r, exp);
        chk("R5 latency", 64'(cyc), 64'(exp_latency(m)));
        chk("R6 busy low at done", 64'(busy_o), 64'd0);
        @(negedge clk);
        chk("R6 done single pulse", 64'(done_o), 64'd0);
        chk("R6 result held", result_o, r);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] r, s, m;
        int cyc;
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk("R1 busy after reset", 64'(busy_o), 64'd0);
        chk("R1 done after reset", 64'(done_o), 64'd0);
        chk("R1 result after reset", result_o, 64'd0);
        rst_n = 1'b1;

        // Table of hand-derived vectors (covers R2, R3, R4, R8)
        for (int v = 0; v < NV; v++) begin
            run_and_check(VEC[v][191:128], VEC[v][127:64], VEC[v][63:0], $sformatf("table %0d", v));
        end

        // R2: bypass is one edge and never raises busy
        do_op(64'h0123456789ABCDEF, 64'h0, r, cyc);
        chk("R2 bypass latency", 64'(cyc), 64'd1);
        chk("R2 bypass result", r, 64'h0123456789ABCDEF);

        // R8: single run reaching the MSB, and single low set bit
        run_and_check(64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000,
                      64'hFFFFFFFFFFFFFFFF, "R8 top bit");
        run_and_check(64'h7FFFFFFFFFFFFFFF, 64'h8000000000000000,
                      64'hFFFFFFFFFFFFFFFE, "R8 top bit zero");

        // Random operands against the bit-serial model (R3, R4, R5)
        for (int i = 0; i < 60; i++) begin
            s = {$urandom, $urandom};
            m = {$urandom, $urandom};
            if (i % 4 == 1) m = m & {$urandom, $urandom};
            run_and_check(s, m, ref_model(s, m), "random");
        end

        // R7: a second request while busy is dropped
        @(negedge clk);
        start_i = 1'b1; src_i = 64'h00000000000000FF; mask_i = 64'h5555555555555555;
        @(negedge clk);
        start_i = 1'b0; cyc = 1;
        repeat (4) begin @(negedge clk); cyc++; end
        start_i = 1'b1; src_i = 64'hFFFFFFFFFFFFFFFF; mask_i = 64'h0;
        @(negedge clk);
        start_i = 1'b0; cyc++;
        while (!done_o && cyc < 200) begin @(negedge clk); cyc++; end
        chk("R7 result of first op", result_o, 64'h0000000F0000000F);
        chk("R7 latency of first op", 64'(cyc), 64'(exp_latency(64'h5555555555555555)));
        r = result_o;
        begin
            int extra = 0;
            repeat (80) begin @(negedge clk); if (done_o) extra++; end
            chk("R7 no extra done", 64'(extra), 64'd0);
            chk("R7 result unchanged", result_o, r);
        end

        // R1: reset in the middle of an operation
        @(negedge clk);
        start_i = 1'b1; src_i = 64'hCAFEF00D12345678; mask_i = 64'h5555555555555555;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 busy after mid reset", 64'(busy_o), 64'd0);
        chk("R1 done after mid reset", 64'(done_o), 64'd0);
        chk("R1 result after mid reset", result_o, 64'd0);
        rst_n = 1'b1;
        run_and_check(64'h1111111122222222, 64'hFFFFFFFF00000000,
                      64'h2222222211111111, "R1 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule